// File: doc/BRIEF.md
# Picture Generator CPU Register Port

This block is the processor-facing register window of a picture generator. A host processor reaches it through an 8-bit data path, three register-select bits, a read/write line and an active-low chip select. The chip select comes from an external address decoder, so the eight-entry window repeats across the whole decoded range. The block holds the control byte, the mask byte, the object-memory address byte, the scroll state and the buffered data-read byte. The scroll state is a 15-bit temporary video address, a 3-bit fine horizontal offset and a first/second-write flag. The bus is split into `data_i`, `data_o` and an output enable `data_oe_o`, and the enable drives the pad tri-state buffer.

The block also runs a simplified frame timer. A clock divider produces dot steps, which advance a dot counter and a line counter, and a parity flag flips at every frame wrap. The asynchronous reset restarts the divider, both counters and the parity flag at once. The reset also starts a hold. During the hold the control, mask, scroll and read-buffer state reads as zero and host writes to it are dropped. The hold lasts until the line counter first steps onto the pre-render line, which is the last line of the frame. Registers outside that set work as soon as reset is released.

Top module: `pic_reg_port`

## Requirements
- R1: An access starts on the first rising clock edge at which `cs_ni` is low after being high. Keeping `cs_ni` low longer does not start a second access. `addr_i` selects one of eight registers.
- R2: The dot counter advances once every CLK_DIV clocks and runs 0..DOTS-1. The line counter advances when the dot counter wraps and runs 0..LINES-1. `odd_frame_o` flips when the line counter wraps to 0.
- R3: A low `rst_ni` asynchronously clears the divider, both counters and `odd_frame_o`, and sets `hold_o`.
- R4: While `hold_o` is 1, the control, mask, temporary address, fine X, write flag and read buffer all read 0. Writes to indices 0, 1 and 5 are dropped, and reads of index 7 do not refill the buffer.
- R5: `hold_o` falls on the dot step that moves the line counter from LINES-2 to LINES-1, and it never rises again until the next reset.
- R6: A write to index 3 loads `obj_addr_o` at any time, including during the hold.
- R7: A write to index 0 loads `ctrl_o` and copies data bits 1:0 into temporary address bits 11:10. `ext_drive_o` equals control bit 6.
- R8: A write to index 1 loads `mask_o`.
- R9: A write to index 5 with the write flag at 0 sets fine X to data[2:0] and temporary address bits 4:0 to data[7:3]. With the flag at 1, it sets address bits 14:12 to data[2:0] and bits 9:5 to data[7:3]. Every such write inverts the flag.
- R10: A read of index 7 returns the read buffer, then loads the buffer from `vram_rdata_i`. A read of any other index returns the last byte written to any index, which is 0 after reset.
- R11: `data_oe_o` is high exactly while `cs_ni` is low and `rw_i` is high. `data_o` holds the value captured at the access start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chip select from the address decoder, active low |
| rw_i | input | 1 | 1 = read, 0 = write |
| addr_i | input | 3 | Register index |
| data_i | input | 8 | Write data from host bus |
| data_o | output | 8 | Read data to host bus |
| data_oe_o | output | 1 | Drive enable for the host data pads |
| vram_rdata_i | input | 8 | Byte fetched from video memory for the read buffer |
| ctrl_o | output | 8 | Control byte |
| mask_o | output | 8 | Mask byte |
| obj_addr_o | output | 8 | Object-memory address byte |
| t_addr_o | output | 15 | Temporary video address |
| fine_x_o | output | 3 | Fine horizontal scroll |
| w_toggle_o | output | 1 | First/second-write flag |
| ext_drive_o | output | 1 | 1 = external colour pins are driven, 0 = sampled |
| dot_o | output | $clog2(DOTS) | Dot counter |
| line_o | output | $clog2(LINES) | Line counter |
| odd_frame_o | output | 1 | Frame parity |
| hold_o | output | 1 | Post-reset hold active |

## Verification
Register writes and the read capture take effect on the access start edge, which is the first rising edge with chip select low. They are visible one edge after the inputs are applied. The counters, parity and hold release change on the edge that ends a divider period. `data_oe_o` follows chip select and the read/write line with no clock delay. The bench applies inputs just after each rising edge and updates a behavioural model on the same edge that the design uses. It compares every output at the falling edge that follows. Directed checks also sample the read data at the falling edge after the access start.

// File: rtl/pic_reg_pkg.sv
package pic_reg_pkg;

  typedef enum logic [2:0] {
    IDX_CTRL = 3'd0,
    IDX_MASK = 3'd1,
    IDX_STAT = 3'd2,
    IDX_OBJA = 3'd3,
    IDX_OBJD = 3'd4,
    IDX_SCRL = 3'd5,
    IDX_VADR = 3'd6,
    IDX_VDAT = 3'd7
  } reg_idx_e;

  // temporary video address layout; field positions are decoded by the renderer
  typedef struct packed {
    logic [2:0] fine_y;
    logic [1:0] nt_sel;
    logic [4:0] coarse_y;
    logic [4:0] coarse_x;
  } vaddr_t;

  typedef struct packed {
    logic       wr;
    logic       rd;
    reg_idx_e   idx;
    logic [7:0] data;
  } host_acc_t;

endpackage

// File: rtl/pic_frame_timer.sv
module pic_frame_timer #(
  parameter int DOTS    = 341,
  parameter int LINES   = 262,
  parameter int CLK_DIV = 4,
  localparam int DOT_W  = $clog2(DOTS),
  localparam int LINE_W = $clog2(LINES),
  localparam int DIV_W  = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [DOT_W-1:0]  dot_o,
  output logic [LINE_W-1:0] line_o,
  output logic              odd_o,
  output logic              hold_o
);

  logic [DIV_W-1:0]  div_q;
  logic [DOT_W-1:0]  dot_q;
  logic [LINE_W-1:0] line_q;
  logic              odd_q, hold_q;
  logic              dot_step, line_end, frame_end, enter_pre;

  assign dot_step  = (div_q == DIV_W'(CLK_DIV - 1));
  assign line_end  = (dot_q == DOT_W'(DOTS - 1));
  assign frame_end = line_end && (line_q == LINE_W'(LINES - 1));
  assign enter_pre = dot_step && line_end && (line_q == LINE_W'(LINES - 2));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      dot_q  <= '0;
      line_q <= '0;
      odd_q  <= 1'b0;
      hold_q <= 1'b1;
    end else begin
      if (dot_step) begin
        div_q <= '0;
        if (line_end) begin
          dot_q <= '0;
          if (frame_end) begin
            line_q <= '0;
            odd_q  <= ~odd_q;
          end else begin
            line_q <= line_q + 1'b1;
          end
        end else begin
          dot_q <= dot_q + 1'b1;
        end
      end else begin
        div_q <= div_q + 1'b1;
      end
      if (enter_pre) hold_q <= 1'b0;
    end
  end

  assign dot_o  = dot_q;
  assign line_o = line_q;
  assign odd_o  = odd_q;
  assign hold_o = hold_q;

endmodule

// File: rtl/pic_host_decode.sv
module pic_host_decode
  import pic_reg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_ni,
  input  logic       rw_i,
  input  logic [2:0] addr_i,
  input  logic [7:0] data_i,
  output host_acc_t  acc_o
);

  logic cs_prev_q;
  logic start;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cs_prev_q <= 1'b1;
    else         cs_prev_q <= cs_ni;
  end

  // one access per chip-select assertion
  assign start = !cs_ni && cs_prev_q;

  always_comb begin
    acc_o.wr   = start && !rw_i;
    acc_o.rd   = start && rw_i;
    acc_o.idx  = reg_idx_e'(addr_i);
    acc_o.data = data_i;
  end

endmodule

// File: rtl/pic_scroll_regs.sv
module pic_scroll_regs
  import pic_reg_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      hold_i,
  input  host_acc_t acc_i,
  output vaddr_t    t_o,
  output logic [2:0] fine_x_o,
  output logic      w_o
);

  vaddr_t     t_q;
  logic [2:0] fx_q;
  logic       w_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      t_q  <= '0;
      fx_q <= '0;
      w_q  <= 1'b0;
    end else if (hold_i) begin
      t_q  <= '0;
      fx_q <= '0;
      w_q  <= 1'b0;
    end else if (acc_i.wr) begin
      unique case (acc_i.idx)
        IDX_CTRL: t_q.nt_sel <= acc_i.data[1:0];
        IDX_SCRL: begin
          if (!w_q) begin
            fx_q        <= acc_i.data[2:0];
            t_q.coarse_x <= acc_i.data[7:3];
          end else begin
            t_q.fine_y   <= acc_i.data[2:0];
            t_q.coarse_y <= acc_i.data[7:3];
          end
          w_q <= ~w_q;
        end
        default: ;
      endcase
    end
  end

  assign t_o      = t_q;
  assign fine_x_o = fx_q;
  assign w_o      = w_q;

endmodule

// File: rtl/pic_reg_port.sv
module pic_reg_port
  import pic_reg_pkg::*;
#(
  parameter int DOTS    = 341,
  parameter int LINES   = 262,
  parameter int CLK_DIV = 4,
  localparam int DOT_W  = $clog2(DOTS),
  localparam int LINE_W = $clog2(LINES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              rw_i,
  input  logic [2:0]        addr_i,
  input  logic [7:0]        data_i,
  output logic [7:0]        data_o,
  output logic              data_oe_o,
  input  logic [7:0]        vram_rdata_i,
  output logic [7:0]        ctrl_o,
  output logic [7:0]        mask_o,
  output logic [7:0]        obj_addr_o,
  output logic [14:0]       t_addr_o,
  output logic [2:0]        fine_x_o,
  output logic              w_toggle_o,
  output logic              ext_drive_o,
  output logic [DOT_W-1:0]  dot_o,
  output logic [LINE_W-1:0] line_o,
  output logic              odd_frame_o,
  output logic              hold_o
);

  localparam int EXT_BIT = 6;

  host_acc_t  acc;
  vaddr_t     t_w;
  logic       hold;
  logic [7:0] ctrl_q, mask_q, obja_q, rbuf_q, bus_q, rd_q;

  pic_frame_timer #(
    .DOTS(DOTS), .LINES(LINES), .CLK_DIV(CLK_DIV)
  ) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .dot_o  (dot_o),
    .line_o (line_o),
    .odd_o  (odd_frame_o),
    .hold_o (hold)
  );

  pic_host_decode u_dec (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cs_ni  (cs_ni),
    .rw_i   (rw_i),
    .addr_i (addr_i),
    .data_i (data_i),
    .acc_o  (acc)
  );

  pic_scroll_regs u_scroll (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hold_i   (hold),
    .acc_i    (acc),
    .t_o      (t_w),
    .fine_x_o (fine_x_o),
    .w_o      (w_toggle_o)
  );

  // held registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      mask_q <= '0;
      rbuf_q <= '0;
    end else if (hold) begin
      ctrl_q <= '0;
      mask_q <= '0;
      rbuf_q <= '0;
    end else begin
      if (acc.wr && acc.idx == IDX_CTRL) ctrl_q <= acc.data;
      if (acc.wr && acc.idx == IDX_MASK) mask_q <= acc.data;
      if (acc.rd && acc.idx == IDX_VDAT) rbuf_q <= vram_rdata_i;
    end
  end

  // registers live from reset release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      obja_q <= '0;
      bus_q  <= '0;
      rd_q   <= '0;
    end else begin
      if (acc.wr) bus_q <= acc.data;
      if (acc.wr && acc.idx == IDX_OBJA) obja_q <= acc.data;
      if (acc.rd) rd_q <= (acc.idx == IDX_VDAT) ? rbuf_q : bus_q;
    end
  end

  assign data_o      = rd_q;
  assign data_oe_o   = !cs_ni && rw_i;
  assign ctrl_o      = ctrl_q;
  assign mask_o      = mask_q;
  assign obj_addr_o  = obja_q;
  assign t_addr_o    = t_w;
  assign ext_drive_o = ctrl_q[EXT_BIT];
  assign hold_o      = hold;

endmodule

// File: rtl/pic_reg_port_chk.sv
module pic_reg_port_chk #(
  parameter int DOTS    = 341,
  parameter int LINES   = 262,
  localparam int DOT_W  = $clog2(DOTS),
  localparam int LINE_W = $clog2(LINES)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              hold_o,
  input logic [7:0]        ctrl_o,
  input logic [7:0]        mask_o,
  input logic [14:0]       t_addr_o,
  input logic [2:0]        fine_x_o,
  input logic              w_toggle_o,
  input logic [DOT_W-1:0]  dot_o,
  input logic [LINE_W-1:0] line_o,
  input logic              odd_frame_o
);

  assert_hold_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_o |-> (ctrl_o == 8'h0 && mask_o == 8'h0 && t_addr_o == 15'h0
                && fine_x_o == 3'h0 && !w_toggle_o));

  assert_hold_end_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hold_o) |-> (line_o == LINE_W'(LINES - 1) && dot_o == '0));

  assert_hold_no_rise_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$rose(hold_o));

  assert_line_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(line_o) && line_o != '0) |-> (line_o == $past(line_o) + 1'b1 && dot_o == '0));

  assert_parity_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(odd_frame_o) |-> (line_o == '0 && dot_o == '0));

endmodule

bind pic_reg_port pic_reg_port_chk #(.DOTS(DOTS), .LINES(LINES)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .hold_o      (hold_o),
  .ctrl_o      (ctrl_o),
  .mask_o      (mask_o),
  .t_addr_o    (t_addr_o),
  .fine_x_o    (fine_x_o),
  .w_toggle_o  (w_toggle_o),
  .dot_o       (dot_o),
  .line_o      (line_o),
  .odd_frame_o (odd_frame_o)
);

// File: tb/pic_reg_port_tb.sv
module pic_reg_port_tb;

  localparam int DOTS = 6, LINES = 5, CLK_DIV = 2;
  localparam int DW = $clog2(DOTS), LW = $clog2(LINES);

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, rw = 1'b1;
  logic [2:0] addr = '0;
  logic [7:0] din = '0, vram = '0;
  logic [7:0] data_o, ctrl_o, mask_o, obj_o;
  logic data_oe, w_o, ext_o, odd_o, hold_o;
  logic [14:0] t_o;
  logic [2:0] fx_o;
  logic [DW-1:0] dot_o;
  logic [LW-1:0] line_o;

  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  pic_reg_port #(.DOTS(DOTS), .LINES(LINES), .CLK_DIV(CLK_DIV)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .rw_i(rw), .addr_i(addr),
    .data_i(din), .data_o(data_o), .data_oe_o(data_oe), .vram_rdata_i(vram),
    .ctrl_o(ctrl_o), .mask_o(mask_o), .obj_addr_o(obj_o), .t_addr_o(t_o),
    .fine_x_o(fx_o), .w_toggle_o(w_o), .ext_drive_o(ext_o), .dot_o(dot_o),
    .line_o(line_o), .odd_frame_o(odd_o), .hold_o(hold_o)
  );

  // behavioural reference
  int m_div, m_dot, m_line;
  bit m_odd, m_hold, m_w, m_csp;
  logic [7:0] m_ctrl, m_mask, m_obj, m_buf, m_bus, m_rd;
  logic [14:0] m_t;
  logic [2:0] m_fx;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_div = 0; m_dot = 0; m_line = 0; m_odd = 0; m_hold = 1; m_w = 0; m_csp = 1;
      m_ctrl = 0; m_mask = 0; m_obj = 0; m_buf = 0; m_bus = 0; m_rd = 0;
      m_t = 0; m_fx = 0;
    end else begin
      if (!cs_n && m_csp) begin
        if (rw) begin
          m_rd = (addr == 3'd7) ? m_buf : m_bus;
          if (addr == 3'd7 && !m_hold) m_buf = vram;
        end else begin
          m_bus = din;
          if (addr == 3'd3) m_obj = din;
          if (!m_hold) begin
            if (addr == 3'd0) begin m_ctrl = din; m_t[11:10] = din[1:0]; end
            if (addr == 3'd1) m_mask = din;
            if (addr == 3'd5) begin
              if (!m_w) begin m_fx = din[2:0]; m_t[4:0] = din[7:3]; end
              else begin m_t[14:12] = din[2:0]; m_t[9:5] = din[7:3]; end
              m_w = !m_w;
            end
          end
        end
      end
      m_csp = cs_n;
      if (m_div == CLK_DIV - 1) begin
        m_div = 0;
        if (m_dot == DOTS - 1 && m_line == LINES - 2) m_hold = 0;
        if (m_dot == DOTS - 1) begin
          m_dot = 0;
          if (m_line == LINES - 1) begin m_line = 0; m_odd = !m_odd; end
          else m_line = m_line + 1;
        end else m_dot = m_dot + 1;
      end else m_div = m_div + 1;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    check("R2 dot", int'(dot_o), m_dot);
    check("R2 line", int'(line_o), m_line);
    check("R2 parity", int'(odd_o), int'(m_odd));
    check("R5 hold", int'(hold_o), int'(m_hold));
    check(m_hold ? "R4 ctrl" : "R7 ctrl", int'(ctrl_o), int'(m_ctrl));
    check(m_hold ? "R4 mask" : "R8 mask", int'(mask_o), int'(m_mask));
    check("R6 obj", int'(obj_o), int'(m_obj));
    check(m_hold ? "R4 taddr" : "R9 taddr", int'(t_o), int'(m_t));
    check(m_hold ? "R4 finex" : "R9 finex", int'(fx_o), int'(m_fx));
    check(m_hold ? "R4 toggle" : "R9 toggle", int'(w_o), int'(m_w));
    check("R7 ext", int'(ext_o), int'(m_ctrl[6]));
    check("R11 oe", int'(data_oe), int'(!cs_n && rw));
    if (!cs_n && rw) check("R10 rdata", int'(data_o), int'(m_rd));
  end

  task automatic cpu_wr(input logic [2:0] a, input logic [7:0] d, input int len = 1);
    @(posedge clk); #1; cs_n = 0; rw = 0; addr = a; din = d;
    for (int i = 0; i < len; i++) @(posedge clk);
    #1; cs_n = 1; rw = 1;
  endtask

  task automatic cpu_rd(input logic [2:0] a, output logic [7:0] d);
    @(posedge clk); #1; cs_n = 0; rw = 1; addr = a;
    @(posedge clk);
    @(negedge clk); d = data_o;
    @(posedge clk); #1; cs_n = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL R2 watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] rv;
    repeat (3) @(posedge clk);
    #1; rst_n = 1;
    @(negedge clk);
    check("R3 reset hold", int'(hold_o), 1);
    check("R3 reset line", int'(line_o), 0);
    check("R10 reset bus", int'(data_o), 0);

    // writes during hold
    cpu_wr(3'd0, 8'hC3);
    cpu_wr(3'd1, 8'h1E);
    cpu_wr(3'd5, 8'h55);
    cpu_wr(3'd3, 8'h44);
    vram = 8'h77;
    cpu_rd(3'd7, rv);
    check("R4 buffer read in hold", int'(rv), 0);
    @(negedge clk);
    check("R4 ctrl held", int'(ctrl_o), 0);
    check("R6 obj during hold", int'(obj_o), 8'h44);

    for (int i = 0; i < 200 && hold_o; i++) @(posedge clk);
    @(negedge clk);
    check("R5 released on pre line", int'(line_o), LINES - 1);

    cpu_wr(3'd0, 8'h41);
    cpu_wr(3'd1, 8'h18);
    cpu_wr(3'd5, 8'hAB);
    cpu_wr(3'd5, 8'h5E);
    @(negedge clk);
    check("R9 taddr", int'(t_o), 25973);
    check("R9 finex", int'(fx_o), 3);
    check("R7 ext drive", int'(ext_o), 1);
    check("R8 mask", int'(mask_o), 8'h18);

    vram = 8'h9C;
    cpu_rd(3'd7, rv);
    check("R10 first buffered read", int'(rv), 0);
    vram = 8'h37;
    cpu_rd(3'd7, rv);
    check("R10 second buffered read", int'(rv), 8'h9C);
    cpu_rd(3'd2, rv);
    check("R10 bus latch read", int'(rv), 8'h5E);

    cpu_wr(3'd5, 8'h08, 4);
    @(negedge clk);
    check("R1 single access on long select", int'(w_o), 1);
    cpu_wr(3'b101, 8'h10);
    @(negedge clk);
    check("R1 index select", int'(w_o), 0);

    repeat (150) @(posedge clk);
    #1; rst_n = 0;
    @(negedge clk);
    check("R3 async clear parity", int'(odd_o), 0);
    check("R3 async set hold", int'(hold_o), 1);
    @(posedge clk); #1; rst_n = 1;
    cpu_wr(3'd1, 8'hFF);
    cpu_wr(3'd3, 8'h12);
    @(negedge clk);
    check("R4 mask write dropped", int'(mask_o), 0);
    check("R6 obj write live", int'(obj_o), 8'h12);
    repeat (80) @(posedge clk);
    cpu_wr(3'd1, 8'h81);
    @(negedge clk);
    check("R8 mask after release", int'(mask_o), 8'h81);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule